// File: doc/BRIEF.md
# Fan Tachometer Period Checker

This block times the interval between successive rising edges of a fan's tachometer pulse, counting system clock cycles. After each completed interval it publishes the count and pulses a strobe. Software can then convert that count into rotational speed using 60 × f_clk / (pulses per revolution × count), where the fan gives 1, 2 or 4 pulses per revolution. A count of zero means that no valid reading is available.

Each completed count is also compared against a window built from a programmed expected period and a tolerance. The tolerance is typically about a quarter of the period. A count outside the window raises a one-cycle error strobe. Writing an expected period of zero suspends the window check. This lets software leave the check off while it captures a fresh reference period after changing the drive duty, and then program the new expected period and tolerance between measurements. If no edge arrives before the cycle counter saturates, the block reports a stalled fan by raising the error strobe alone and clearing the published count.

The controller has three states. `ST_IDLE` means enable is low. `ST_ARM` waits for a first edge. `ST_COUNT` times an interval. The transitions are as follows:
- idle→arm when enable goes high.
- arm→count on a synchronized rising edge.
- count→count on each further edge, which completes a measurement.
- count→arm on saturation without an edge, which is a stall.
- any state→idle whenever enable is low.

Top module: `fan_tach_checker`

## Requirements
- R1: After reset the published count is 0 and both strobes are low.
- R2: The tach input passes through a two-flop synchronizer. The count equals the number of clock cycles between two consecutive synchronized rising edges. The first edge after enable only starts timing, so N edges yield N−1 measurements.
- R3: `meas_valid` is high for exactly one cycle per completed measurement. `meas_period` takes the new, nonzero count in that same cycle and changes at no other time, except for a stall.
- R4: When `exp_period` is nonzero, `tach_err` pulses together with `meas_valid` if the count is below exp−tol or above exp+tol. A count equal to either bound is accepted.
- R5: The lower bound clamps at 0 when `tolerance` ≥ `exp_period`. The upper bound is formed one bit wider than the count, so it never wraps.
- R6: When `exp_period` is 0, no measurement raises `tach_err`.
- R7: If the counter reaches 2^CNT_W−1 with no edge, the block signals a stall. It pulses `tach_err` without `meas_valid`, sets `meas_period` to 0 and re-arms. An edge arriving in the saturation cycle still completes a measurement of 2^CNT_W−1.
- R8: While `enable` is low, no strobe is raised and `meas_period` holds its value. When enable returns high, timing restarts from the next edge.
- R9: `exp_period` and `tolerance` are sampled in the cycle a measurement completes. New values written between measurements apply to the next comparison.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Run enable; low forces idle |
| tach_in | input | 1 | Asynchronous tachometer pulse |
| exp_period | input | CNT_W | Expected period in cycles; 0 disables the check |
| tolerance | input | CNT_W | Allowed deviation in cycles |
| meas_period | output | CNT_W | Latest measured period; 0 means no reading |
| meas_valid | output | 1 | One-cycle strobe on each new measurement |
| tach_err | output | 1 | One-cycle strobe on window violation or stall |

## Verification
Directed pulse trains place the period exactly on each window bound and one cycle beyond it. This separates inclusive from exclusive comparisons. Further trains set the tolerance above the expected period and put the upper bound past the count width, which would expose a lower bound that wraps or an upper bound that overflows. A train with a zero expected period, a silent input longer than the saturation limit, a period of exactly the saturation value and pulses sent while disabled each isolate one of the unchecked, stall and gating paths. Random trains with fresh expected and tolerance values each time check the measured count and the error decision against a model computed in the bench.

// File: rtl/fan_tach_pkg.sv
package fan_tach_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARM   = 2'd1,
        ST_COUNT = 2'd2
    } tach_state_e;

endpackage

// File: rtl/tach_sync.sv
module tach_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic rise_o
);
    // STAGES synchronizer flops plus one history flop for edge detect
    logic [STAGES:0] shreg;

    always_ff @(posedge clk) begin
        if (!rst_n) shreg <= '0;
        else        shreg <= {shreg[STAGES-1:0], async_i};
    end

    assign rise_o = shreg[STAGES-1] & ~shreg[STAGES];

endmodule

// File: rtl/tach_window.sv
module tach_window #(
    parameter int W = 20
) (
    input  logic [W-1:0] meas_i,
    input  logic [W-1:0] exp_i,
    input  logic [W-1:0] tol_i,
    output logic         bad_o
);
    localparam int EW = W + 1;

    logic [EW-1:0] lo_bound;
    logic [EW-1:0] hi_bound;
    logic [EW-1:0] meas_ext;

    always_comb begin
        meas_ext = {1'b0, meas_i};
        lo_bound = (exp_i > tol_i) ? {1'b0, exp_i - tol_i} : '0;
        hi_bound = {1'b0, exp_i} + {1'b0, tol_i};
        bad_o    = (exp_i != '0) && ((meas_ext < lo_bound) || (meas_ext > hi_bound));
    end

endmodule

// File: rtl/tach_period_fsm.sv
module tach_period_fsm
    import fan_tach_pkg::*;
#(
    parameter int W = 20
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         enable_i,
    input  logic         rise_i,
    input  logic         win_bad_i,
    output logic [W-1:0] cnt_o,
    output logic [W-1:0] meas_o,
    output logic         valid_o,
    output logic         err_o
);
    localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

    tach_state_e state, state_n;
    logic [W-1:0] cnt;
    logic         done_ev;
    logic         stall_ev;

    assign cnt_o = cnt;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    // next state
    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE:  if (enable_i) state_n = ST_ARM;
            ST_ARM:   if (rise_i)   state_n = ST_COUNT;
            ST_COUNT: if (!rise_i && cnt == CNT_MAX) state_n = ST_ARM;
            default:  state_n = ST_IDLE;
        endcase
        if (!enable_i) state_n = ST_IDLE;
    end

    assign done_ev  = enable_i && (state == ST_COUNT) && rise_i;
    assign stall_ev = enable_i && (state == ST_COUNT) && !rise_i && (cnt == CNT_MAX);

    // interval counter
    always_ff @(posedge clk) begin
        if (!rst_n || !enable_i) begin
            cnt <= '0;
        end else begin
            unique case (state)
                ST_ARM:   if (rise_i) cnt <= W'(1);
                ST_COUNT: begin
                    if (rise_i)              cnt <= W'(1);
                    else if (cnt == CNT_MAX) cnt <= '0;
                    else                     cnt <= cnt + W'(1);
                end
                default:  cnt <= '0;
            endcase
        end
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meas_o  <= '0;
            valid_o <= 1'b0;
            err_o   <= 1'b0;
        end else begin
            valid_o <= done_ev;
            err_o   <= (done_ev && win_bad_i) || stall_ev;
            if (done_ev)       meas_o <= cnt;
            else if (stall_ev) meas_o <= '0;
        end
    end

    // R3: the valid strobe lasts one cycle
    a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    // R3: a published measurement is never zero
    a_r3_nonzero_meas: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (meas_o != '0));

    // R7: the count moves only with a measurement or a stall
    a_r7_meas_moves_on_event: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(meas_o) |-> (valid_o || err_o));

    // R7: an error without a measurement leaves a zero count
    a_r7_stall_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (err_o && !valid_o) |-> (meas_o == '0));

    // R8: disabled means no strobes next cycle
    a_r8_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_i |=> (!valid_o && !err_o));

endmodule

// File: rtl/fan_tach_checker.sv
module fan_tach_checker #(
    parameter int CNT_W     = 20,
    parameter int SYNC_DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             tach_in,
    input  logic [CNT_W-1:0] exp_period,
    input  logic [CNT_W-1:0] tolerance,
    output logic [CNT_W-1:0] meas_period,
    output logic             meas_valid,
    output logic             tach_err
);
    logic             tach_rise;
    logic             win_bad;
    logic [CNT_W-1:0] live_cnt;

    tach_sync #(.STAGES(SYNC_DEPTH)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (tach_in),
        .rise_o  (tach_rise)
    );

    tach_window #(.W(CNT_W)) u_window (
        .meas_i (live_cnt),
        .exp_i  (exp_period),
        .tol_i  (tolerance),
        .bad_o  (win_bad)
    );

    tach_period_fsm #(.W(CNT_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable_i  (enable),
        .rise_i    (tach_rise),
        .win_bad_i (win_bad),
        .cnt_o     (live_cnt),
        .meas_o    (meas_period),
        .valid_o   (meas_valid),
        .err_o     (tach_err)
    );

    // R6: an unprogrammed expected period never flags a measurement
    a_r6_no_check_when_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (meas_valid && ($past(exp_period) == '0)) |-> !tach_err);

endmodule

// File: tb/fan_tach_checker_test.sv
module fan_tach_checker_test;

    localparam int W    = 12;
    localparam int CMAX = (1 << W) - 1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         enable = 1'b0;
    logic         tach_in = 1'b0;
    logic [W-1:0] exp_period = '0;
    logic [W-1:0] tolerance = '0;
    logic [W-1:0] meas_period;
    logic         meas_valid;
    logic         tach_err;

    int checks = 0;
    int fails = 0;
    int cur_p = 0;
    string cur_req = "R2";
    int n_strobe = 0;
    int n_err_ev = 0;
    int n_stall = 0;
    bit done_flag = 1'b0;

    always #10 clk = ~clk;

    fan_tach_checker #(.CNT_W(W)) uut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .tach_in(tach_in),
        .exp_period(exp_period), .tolerance(tolerance),
        .meas_period(meas_period), .meas_valid(meas_valid), .tach_err(tach_err)
    );

    function automatic bit want_err(input int p, input int e, input int t);
        int lo;
        int hi;
        if (e == 0) return 1'b0;
        lo = (e > t) ? e - t : 0;
        hi = e + t;
        return (p < lo) || (p > hi);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    // monitor away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (meas_valid) begin
                n_strobe++;
                chk(meas_period == W'(cur_p), {cur_req, " period"}, int'(meas_period), cur_p);
                chk(tach_err == want_err(cur_p, int'(exp_period), int'(tolerance)),
                    {cur_req, " error decision"}, int'(tach_err),
                    int'(want_err(cur_p, int'(exp_period), int'(tolerance))));
            end
            if (tach_err) n_err_ev++;
            if (tach_err && !meas_valid) n_stall++;
        end
    end

    task automatic pulses(input int p, input int n);
        int hi_len;
        hi_len = p / 2;
        for (int i = 0; i < n; i++) begin
            tach_in = 1'b1;
            repeat (hi_len) @(negedge clk);
            tach_in = 1'b0;
            repeat (p - hi_len) @(negedge clk);
        end
    endtask

    task automatic train(input int p, input int n, input int e, input int t, input string req);
        int s0;
        enable = 1'b0;
        repeat (3) @(negedge clk);
        exp_period = W'(e);
        tolerance  = W'(t);
        cur_p = p;
        cur_req = req;
        enable = 1'b1;
        repeat (4) @(negedge clk);
        s0 = n_strobe;
        pulses(p, n);
        repeat (6) @(negedge clk);
        chk(n_strobe - s0 == n - 1, {req, " measurement count"}, n_strobe - s0, n - 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        int s_st;
        int s_ev;
        int s_str;
        logic [W-1:0] held;
        void'($urandom(32'd4711));
        repeat (4) @(negedge clk);
        // R1 reset state
        chk(meas_period == '0, "R1 count", int'(meas_period), 0);
        chk(meas_valid == 1'b0, "R1 valid", int'(meas_valid), 0);
        chk(tach_err == 1'b0, "R1 err", int'(tach_err), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(meas_period == '0, "R1 count after release", int'(meas_period), 0);

        // R2 basic measurement
        train(100, 4, 100, 25, "R2");
        // R4 inclusive bounds and one past
        train(75, 3, 100, 25, "R4");
        train(74, 3, 100, 25, "R4");
        train(125, 3, 100, 25, "R4");
        train(126, 3, 100, 25, "R4");
        // R6 unprogrammed expected period
        train(37, 3, 0, 5, "R6");
        // R5 lower clamp and wide upper bound
        train(3, 3, 10, 20, "R5");
        train(4095, 3, 4000, 200, "R5");
        train(3700, 3, 4000, 200, "R4");
        chk(n_err_ev > 0, "R4 errors seen", n_err_ev, 1);

        // R7 stall after silence, then re-arm
        train(50, 3, 50, 10, "R7");
        s_st = n_stall;
        repeat (CMAX + 100) @(negedge clk);
        chk(n_stall - s_st == 1, "R7 stall count", n_stall - s_st, 1);
        chk(meas_period == '0, "R7 count cleared", int'(meas_period), 0);
        train(60, 3, 60, 0, "R7");

        // R8 disabled: pulses have no effect
        held = meas_period;
        enable = 1'b0;
        s_ev = n_err_ev;
        s_str = n_strobe;
        repeat (3) @(negedge clk);
        pulses(20, 5);
        repeat (6) @(negedge clk);
        chk(n_strobe == s_str, "R8 no strobe", n_strobe - s_str, 0);
        chk(n_err_ev == s_ev, "R8 no error", n_err_ev - s_ev, 0);
        chk(meas_period == held, "R8 count held", int'(meas_period), int'(held));
        train(40, 3, 40, 4, "R8");

        // R9 random trains with new limits each time
        for (int k = 0; k < 12; k++) begin
            int p;
            int e;
            int t;
            p = int'($urandom_range(300, 30));
            e = p + int'($urandom_range(40, 0)) - 20;
            t = int'($urandom_range(p / 4, 0));
            train(p, 4, e, t, "R9");
        end

        finish_run();
    end

endmodule